// File: doc/BRIEF.md
# PLL Lock Sequencer with Frequency Check

This block brings an on-chip PLL up from a single configuration word and then checks the result. When it gets a start strobe, it captures the word and splits it into a multiplier, a pre-divider and an output divider, which it drives to the PLL. It then runs a bring-up attempt: reset is raised with enable low, enable is raised while reset is still held, and reset is released. After a settle window it samples the lock indication. If lock is missing, the whole attempt repeats, up to a fixed number of tries.

Once lock is seen, the block computes the frequency the configuration should give: a reference in MHz is divided by the pre-divider using integer division, multiplied by the multiplier, and shifted right by the output divider. The result is shifted right by four more places, because an external counter measures the clock after a fixed divide-by-16. The block compares this against the measured count with a tolerance of two in either direction.

When the sequence ends, the block gives a one-cycle done pulse and holds a status code. The code is zero on success, 0x1000 when lock never came, and 0x0001 when the frequency is off.

Top module: `pll_lock_seq`

## Requirements
- R1: On an accepted start, the block captures `cfgWord`. It drives multiplier bits [8:0] on `pllMult`, pre-divider bits [14:10] on `pllPreDiv` and output-divider bits [17:16] on `pllOutDiv`, and holds these values unchanged until the run ends.
- R2: Each attempt runs in this order: one cycle with `pllReset` high and `pllEnable` low, then one cycle with both high, then `pllReset` low with `pllEnable` held high.
- R3: After reset is released, the block waits `SETTLE_CYC` cycles (default 20) and then samples lock in one further cycle. The settle window restarts on every retry, so successive rising edges of `pllReset` are `SETTLE_CYC`+3 cycles apart.
- R4: If lock is absent at the sample, the attempt repeats. After `MAX_TRY` attempts (default 20) without lock, the run ends with status 0x1000.
- R5: With `lockMode`=0, lock means `pllLock`=1. With `lockMode`=1, lock needs both `pllLock` and `pllLockAux` to be 1. `lockMode` is captured at start.
- R6: After lock, the expected count is ((REF_MHZ / N, integer division) * M >> OD) >> 4. A `measCount` within ±2 of this value, inclusive, gives status 0x0000. Any other value gives 0x0001.
- R7: `done` is high for exactly one cycle per run. `statusCode` changes only on that cycle and holds its value until the next run ends.
- R8: A start strobe that arrives while a run is in progress is ignored.
- R9: A configuration with N=0 ends at once with status 0x1000 and no reset pulse. `done` rises in the cycle after the start.
- R10: Reset state: `busy`, `done`, `pllReset` and `pllEnable` are low and `statusCode` is 0. `busy` is high from the cycle after an accepted start (N≠0) until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe |
| cfgWord | input | 18 | Configuration word: M [8:0], N [14:10], OD [17:16] |
| lockMode | input | 1 | 0: single lock bit, 1: both lock bits required |
| pllLock | input | 1 | Primary lock indication from the PLL |
| pllLockAux | input | 1 | Secondary lock indication used when lockMode=1 |
| measCount | input | MEAS_W | Measured count from the external counter (after divide-by-16) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| statusCode | output | 16 | Held result: 0x0000 pass, 0x1000 no lock, 0x0001 frequency off |
| pllMult | output | 9 | Multiplier field to the PLL |
| pllPreDiv | output | 5 | Pre-divider field to the PLL |
| pllOutDiv | output | 2 | Output-divider field to the PLL |
| pllReset | output | 1 | PLL reset |
| pllEnable | output | 1 | PLL enable |

## Verification
The bound checker checks some properties on every cycle:
- the reset/enable ordering around each reset edge;
- the single-cycle done pulse and the legal, held status codes;
- that the fields stay stable during a run;
- that a run never issues more than `MAX_TRY` reset pulses.

Other behaviour only shows through the bench's scenarios, which compare results against a model of the PLL and an independent computation of the expected count:
- the retry count before a late lock;
- the settle spacing;
- the integer-division order in the expected frequency;
- both edges of the ±2 window;
- the dual-bit lock mode;
- the N=0 shortcut;
- that a start strobe during a run is ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  // configuration word layout (positions are decoded by the PLL fields)
  localparam int CFG_W  = 18;
  localparam int M_LSB  = 0;
  localparam int M_W    = 9;
  localparam int N_LSB  = 10;
  localparam int N_W    = 5;
  localparam int OD_LSB = 16;
  localparam int OD_W   = 2;

  // measurement is taken after a fixed divide-by-16
  localparam int POST_SHIFT = 4;

  localparam int CODE_W = 16;
  localparam logic [CODE_W-1:0] CODE_OK     = 16'h0000;
  localparam logic [CODE_W-1:0] CODE_NOLOCK = 16'h1000;
  localparam logic [CODE_W-1:0] CODE_FREQ   = 16'h0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARM,
    ST_SETTLE,
    ST_SAMPLE,
    ST_CHECK
  } seqState_t;

  typedef struct packed {
    logic loadCfg;
    logic clrTry;
    logic incTry;
    logic clrSettle;
    logic runSettle;
    logic finOk;
    logic finNoLock;
    logic finFreq;
  } seqCtl_t;

endpackage

// File: rtl/pll_seq_datapath.sv
module pll_seq_datapath
  import pll_seq_pkg::*;
#(
  parameter int REF_MHZ    = 24,
  parameter int SETTLE_CYC = 20,
  parameter int MAX_TRY    = 20,
  parameter int MEAS_W     = 16,
  parameter int TOL        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              lockMode,
  input  logic              pllLock,
  input  logic              pllLockAux,
  input  logic [MEAS_W-1:0] measCount,
  output logic              cfgNZero,
  output logic              settleDone,
  output logic              lastTry,
  output logic              lockSeen,
  output logic              freqOk,
  output logic [M_W-1:0]    pllMult,
  output logic [N_W-1:0]    pllPreDiv,
  output logic [OD_W-1:0]   pllOutDiv,
  output logic [CODE_W-1:0] statusCode,
  output logic              done
);

  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int REF_W = $clog2(REF_MHZ + 1);
  localparam int EXP_W = REF_W + M_W;
  localparam int CMP_W = ((MEAS_W > EXP_W) ? MEAS_W : EXP_W) + 2;
  localparam logic signed [CMP_W-1:0] TOL_S = CMP_W'(TOL);

  logic [CFG_W-1:0]  cfgReg;
  logic              modeReg;
  logic [TRY_W-1:0]  tryCnt;
  logic [SET_W-1:0]  settleCnt;
  logic [M_W-1:0]    mVal;
  logic [N_W-1:0]    nVal;
  logic [OD_W-1:0]   odVal;
  logic [REF_W-1:0]  refPerN;
  logic [EXP_W-1:0]  vcoProd;
  logic [EXP_W-1:0]  expCount;
  logic signed [CMP_W-1:0] freqDiff;
  logic              unusedGapBits;

  assign cfgNZero = (cfgWord[N_LSB +: N_W] == '0);

  assign mVal  = cfgReg[M_LSB  +: M_W];
  assign nVal  = cfgReg[N_LSB  +: N_W];
  assign odVal = cfgReg[OD_LSB +: OD_W];
  assign unusedGapBits = ^{cfgReg[M_LSB+M_W], cfgReg[N_LSB+N_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg  <= '0;
      modeReg <= 1'b0;
    end else if (ctl.loadCfg) begin
      cfgReg  <= cfgWord;
      modeReg <= lockMode;
    end
  end

  // attempt counter
  always_ff @(posedge clk) begin
    if (!rst_n)           tryCnt <= '0;
    else if (ctl.clrTry)  tryCnt <= '0;
    else if (ctl.incTry)  tryCnt <= tryCnt + 1'b1;
  end
  assign lastTry = (tryCnt == TRY_W'(MAX_TRY - 1));

  // settle window counter, restarted on every attempt
  always_ff @(posedge clk) begin
    if (!rst_n)              settleCnt <= '0;
    else if (ctl.clrSettle)  settleCnt <= '0;
    else if (ctl.runSettle)  settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == SET_W'(SETTLE_CYC - 1));

  // lock qualification
  generate
    if (1) begin : g_lock
      always_comb begin
        if (modeReg) lockSeen = pllLock & pllLockAux;
        else         lockSeen = pllLock;
      end
    end
  endgenerate

  // expected count: integer divide first, then multiply, then shifts
  always_comb begin
    if (nVal == '0) refPerN = '0;
    else            refPerN = REF_W'(32'(REF_MHZ) / 32'(nVal));
    vcoProd  = EXP_W'(refPerN) * EXP_W'(mVal);
    expCount = (vcoProd >> odVal) >> POST_SHIFT;
    freqDiff = $signed(CMP_W'(measCount)) - $signed(CMP_W'(expCount));
    freqOk   = (freqDiff <= TOL_S) && (freqDiff >= -TOL_S);
  end

  // result register and done pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusCode <= CODE_OK;
      done       <= 1'b0;
    end else begin
      done <= ctl.finOk | ctl.finNoLock | ctl.finFreq;
      if (ctl.finOk)          statusCode <= CODE_OK;
      else if (ctl.finNoLock) statusCode <= CODE_NOLOCK;
      else if (ctl.finFreq)   statusCode <= CODE_FREQ;
    end
  end

  assign pllMult   = mVal;
  assign pllPreDiv = nVal;
  assign pllOutDiv = odVal;

endmodule

// File: rtl/pll_seq_control.sv
module pll_seq_control
  import pll_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    cfgNZero,
  input  logic    settleDone,
  input  logic    lastTry,
  input  logic    lockSeen,
  input  logic    freqOk,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    pllReset,
  output logic    pllEnable
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadCfg = 1'b1;
          ctl.clrTry  = 1'b1;
          if (cfgNZero) ctl.finNoLock = 1'b1;
          else          stateNext     = ST_LOAD;
        end
      end
      ST_LOAD: stateNext = ST_ARM;
      ST_ARM: begin
        ctl.clrSettle = 1'b1;
        stateNext     = ST_SETTLE;
      end
      ST_SETTLE: begin
        ctl.runSettle = 1'b1;
        if (settleDone) stateNext = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (lockSeen) begin
          stateNext = ST_CHECK;
        end else if (lastTry) begin
          ctl.finNoLock = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          ctl.incTry = 1'b1;
          stateNext  = ST_LOAD;
        end
      end
      ST_CHECK: begin
        if (freqOk) ctl.finOk   = 1'b1;
        else        ctl.finFreq = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign pllReset  = (state == ST_LOAD) || (state == ST_ARM);
  assign pllEnable = (state == ST_ARM) || (state == ST_SETTLE) ||
                     (state == ST_SAMPLE) || (state == ST_CHECK);

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_MHZ    = 24,
  parameter int SETTLE_CYC = 20,
  parameter int MAX_TRY    = 20,
  parameter int MEAS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [17:0]       cfgWord,
  input  logic              lockMode,
  input  logic              pllLock,
  input  logic              pllLockAux,
  input  logic [MEAS_W-1:0] measCount,
  output logic              busy,
  output logic              done,
  output logic [15:0]       statusCode,
  output logic [8:0]        pllMult,
  output logic [4:0]        pllPreDiv,
  output logic [1:0]        pllOutDiv,
  output logic              pllReset,
  output logic              pllEnable
);

  seqCtl_t ctl;
  logic    cfgNZero, settleDone, lastTry, lockSeen, freqOk;

  pll_seq_control ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgNZero(cfgNZero), .settleDone(settleDone), .lastTry(lastTry),
    .lockSeen(lockSeen), .freqOk(freqOk), .ctl(ctl),
    .busy(busy), .pllReset(pllReset), .pllEnable(pllEnable)
  );

  pll_seq_datapath #(
    .REF_MHZ(REF_MHZ), .SETTLE_CYC(SETTLE_CYC), .MAX_TRY(MAX_TRY),
    .MEAS_W(MEAS_W), .TOL(2)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cfgWord(cfgWord),
    .lockMode(lockMode), .pllLock(pllLock), .pllLockAux(pllLockAux),
    .measCount(measCount), .cfgNZero(cfgNZero), .settleDone(settleDone),
    .lastTry(lastTry), .lockSeen(lockSeen), .freqOk(freqOk),
    .pllMult(pllMult), .pllPreDiv(pllPreDiv), .pllOutDiv(pllOutDiv),
    .statusCode(statusCode), .done(done)
  );

endmodule

// File: rtl/pll_lock_seq_chk.sv
module pll_lock_seq_chk #(
  parameter int MAX_TRY = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] statusCode,
  input logic [8:0]  pllMult,
  input logic        pllReset,
  input logic        pllEnable
);

  logic        rstSeen;
  logic [15:0] riseCount;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstSeen   <= 1'b0;
      riseCount <= '0;
    end else begin
      rstSeen <= pllReset;
      if (done)                     riseCount <= '0;
      else if (pllReset && !rstSeen) riseCount <= riseCount + 1'b1;
    end
  end

  // R2
  rst_then_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pllReset) |-> !pllEnable);
  // R2
  arm_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pllReset) |=> (pllReset && pllEnable));
  // R2
  release_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pllReset) |-> pllEnable);
  // R4
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    riseCount <= 16'(MAX_TRY));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(statusCode));
  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusCode == 16'h0000) || (statusCode == 16'h0001) || (statusCode == 16'h1000));
  // R1
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pllMult));
  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind pll_lock_seq pll_lock_seq_chk #(.MAX_TRY(MAX_TRY)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .statusCode(statusCode), .pllMult(pllMult),
  .pllReset(pllReset), .pllEnable(pllEnable)
);

// File: tb/pll_lock_seq_tb_top.sv
module pll_lock_seq_tb_top;

  localparam int SETTLE = 20;
  localparam int TRIES  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] cfgWord = '0;
  logic        lockMode = 1'b0;
  logic        pllLock;
  logic        pllLockAux;
  logic [15:0] measCount = '0;
  logic        busy, done, pllReset, pllEnable;
  logic [15:0] statusCode;
  logic [8:0]  pllMult;
  logic [4:0]  pllPreDiv;
  logic [1:0]  pllOutDiv;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int base = 0;
  int lockAt = 0;
  logic auxVal = 1'b0;
  int doneSeen = 0;
  int cycle = 0;
  int lastRise = -1;
  logic prevRst = 1'b0;
  logic prevArm = 1'b0;
  logic finished = 1'b0;

  typedef struct { logic [15:0] code; int tries; string tag; } expItem_t;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  assign pllLock = (lockAt != 0) && ((rises - base) >= lockAt) && pllEnable && !pllReset;
  assign pllLockAux = auxVal;

  pll_lock_seq #(.SETTLE_CYC(SETTLE), .MAX_TRY(TRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgWord(cfgWord),
    .lockMode(lockMode), .pllLock(pllLock), .pllLockAux(pllLockAux),
    .measCount(measCount), .busy(busy), .done(done), .statusCode(statusCode),
    .pllMult(pllMult), .pllPreDiv(pllPreDiv), .pllOutDiv(pllOutDiv),
    .pllReset(pllReset), .pllEnable(pllEnable)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expCnt(input int m, input int n, input int od);
    if (n == 0) return 0;
    return (((24 / n) * m) >> od) >> 4;
  endfunction

  // monitor: reset/enable ordering, spacing, scoreboard compare
  always @(negedge clk) begin
    cycle++;
    if (rst_n) begin
      if (prevArm) begin
        check("R2 arm phase", {31'd0, pllReset && pllEnable}, 1);
        prevArm = 1'b0;
      end
      if (pllReset && !prevRst) begin
        rises++;
        check("R2 enable low on reset rise", {31'd0, pllEnable}, 0);
        prevArm = 1'b1;
        if (lastRise >= 0) check("R3 retry spacing", cycle - lastRise, SETTLE + 3);
        lastRise = cycle;
      end
      if (!pllReset && prevRst) check("R2 enable on release", {31'd0, pllEnable}, 1);
      if (done) begin
        expItem_t it;
        lastRise = -1;
        doneSeen++;
        if (sbQ.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          it = sbQ.pop_front();
          check({it.tag, " status"}, int'(statusCode), int'(it.code));
          check({it.tag, " attempts"}, rises - base, it.tries);
        end
      end
    end
    prevRst = pllReset;
  end

  task automatic runCase(input string tag, input int m, input int n, input int od,
                         input logic mode, input logic aux, input int lkAt,
                         input int delta, input logic [15:0] code, input int tries);
    expItem_t it;
    int target;
    int mv;
    mv = expCnt(m, n, od) + delta;
    if (mv < 0) mv = 0;
    @(negedge clk);
    cfgWord   = {od[1:0], 1'b0, n[4:0], 1'b0, m[8:0]};
    lockMode  = mode;
    auxVal    = aux;
    lockAt    = lkAt;
    measCount = mv[15:0];
    base      = rises;
    it.code = code; it.tries = tries; it.tag = tag;
    sbQ.push_back(it);
    target = doneSeen + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n != 0) begin
      @(negedge clk);
      check("R1 mult field", int'(pllMult), m);
      check("R1 prediv field", int'(pllPreDiv), n);
      check("R1 outdiv field", int'(pllOutDiv), od);
      check("R10 busy during run", {31'd0, busy}, 1);
    end
    while (doneSeen < target) @(negedge clk);
    @(negedge clk);
    check("R7 done one cycle", {31'd0, done}, 0);
    check("R7 status held", int'(statusCode), int'(code));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy reset", {31'd0, busy}, 0);
    check("R10 done reset", {31'd0, done}, 0);
    check("R10 status reset", int'(statusCode), 0);
    check("R10 reset out", {31'd0, pllReset}, 0);
    check("R10 enable out", {31'd0, pllEnable}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runCase("R6 exact", 136, 1, 3, 1'b0, 1'b0, 1, 0, 16'h0000, 1);
    runCase("R4 late lock", 200, 1, 3, 1'b0, 1'b0, 3, 2, 16'h0000, 3);
    runCase("R6 high edge out", 200, 1, 3, 1'b0, 1'b0, 1, 3, 16'h0001, 1);
    runCase("R6 low edge in", 152, 1, 2, 1'b0, 1'b0, 1, -2, 16'h0000, 1);
    runCase("R6 low edge out", 152, 1, 2, 1'b0, 1'b0, 1, -3, 16'h0001, 1);
    runCase("R4 never lock", 136, 1, 3, 1'b0, 1'b0, 0, 0, 16'h1000, TRIES);
    runCase("R5 aux missing", 136, 1, 3, 1'b1, 1'b0, 1, 0, 16'h1000, TRIES);
    runCase("R5 aux present", 136, 1, 3, 1'b1, 1'b1, 1, 0, 16'h0000, 1);
    runCase("R9 zero prediv", 100, 0, 1, 1'b0, 1'b0, 1, 0, 16'h1000, 0);
    runCase("R6 integer divide", 200, 5, 1, 1'b0, 1'b0, 1, 0, 16'h0000, 1);

    // R8: start during a run is ignored
    fork
      runCase("R8 busy start", 136, 1, 3, 1'b0, 1'b0, 2, 0, 16'h0000, 2);
      begin
        repeat (8) @(negedge clk);
        cfgWord = {2'd1, 1'b0, 5'd2, 1'b0, 9'd7};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R8 mult kept", int'(pllMult), 136);
        check("R8 prediv kept", int'(pllPreDiv), 1);
      end
    join
    repeat (5) @(negedge clk);
    check("R8 no extra done", doneSeen, 11);
    check("R8 scoreboard empty", sbQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule